// File: doc/BRIEF.md
# Interrupt Edge and Level Capture

This block watches one asynchronous interrupt line from an external memory device, such as a ready/busy pin. It turns activity on that line into three sticky status flags: a rising edge was seen, a high level was seen, and a falling edge was seen. The hardware sets each flag. Software clears a flag by writing zero to its bit.

Each kind of detection has its own enable bit. A single interrupt request goes high whenever any flag is set while its enable is also set. The raw line first passes through a synchronizer. An edge is found by comparing the synchronized value with a copy delayed by one cycle. If a hardware set and a software clear hit the same flag in the same cycle, the set is kept, so no event is lost.

Software reaches the enables and the flags through a plain write strobe with write data and a continuously driven read word. Register bit map: bit 0 is rising status, bit 1 is high-level status, bit 2 is falling status, bit 3 is rising enable, bit 4 is high-level enable and bit 5 is falling enable.

Top module: `irq_event_capture`

## Requirements
- R1: After reset, all status flags and enables are zero, `rd_data_o` reads 0 and `irq_o` is low.
- R2: A low-to-high change on `irq_line_i` sets rising status (bit 0) on the third rising clock edge after the change. With the input driven just after a clock edge, the flag reads 0 after the second edge and 1 after the third. The flag stays set after the line falls again.
- R3: High-level status (bit 1) is set on every cycle in which the synchronized line is high, and it stays set after the line goes low.
- R4: A high-to-low change on `irq_line_i` sets falling status (bit 2) with the same three-edge latency as R2. Rising status is not set by a falling edge.
- R5: A write with `wr_en_i` high clears every status bit (0..2) whose data bit is 0. Status bits whose data bit is 1 are left unchanged.
- R6: When a hardware set and a software clear of the same status flag fall in the same cycle, the flag reads 1 afterwards.
- R7: A write loads rising, high-level and falling enables from data bits 3, 4 and 5, and these bits read back in the same positions.
- R8: `irq_o` is high exactly when some status flag is set and its enable is set. A status flag whose enable is clear still sets, but it does not raise `irq_o`.
- R9: Read bits above bit 5 are always 0, and write data above bit 5 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_line_i | input | 1 | Raw asynchronous interrupt line |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | DATA_W | Register write data |
| rd_data_o | output | DATA_W | Register read data: status and enables |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A wrong flag state appears at the ports right away. The read word exposes every flag and enable on the clock edge after the fault, and `irq_o` follows the masked flags combinationally. A fault in the synchronizer or edge detector shows up as a flag that sets one edge too early or too late against the three-edge latency. It can also show up as the wrong flag being set. A broken priority between set and clear shows up as a lost flag when software writes zero in exactly the cycle a detection lands.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;
  localparam int unsigned NUM_EVT = 3;
  localparam int unsigned EVT_RISE = 0;
  localparam int unsigned EVT_HIGH = 1;
  localparam int unsigned EVT_FALL = 2;
  localparam int unsigned EN_BASE = NUM_EVT;
  localparam int unsigned USED_W = 2 * NUM_EVT;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

  initial assert (STAGES >= 2) else $error("irq_sync: STAGES must be at least 2");
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o,
  output logic high_o
);
  logic dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly_q <= 1'b0;
    else         dly_q <= level_i;
  end

  assign rise_o = level_i & ~dly_q;
  assign fall_o = ~level_i & dly_q;
  assign high_o = level_i;

  assert_rise_not_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> !fall_o);
  assert_rise_implies_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> high_o);
  assert_fall_after_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> $past(high_o));
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set has priority so a detection is never dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/irq_event_capture.sv
module irq_event_capture
  import irq_cap_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_line_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int unsigned PAD_W = DATA_W - USED_W;

  logic               line_sync;
  logic               ev_rise, ev_fall, ev_high;
  logic [NUM_EVT-1:0] ev_set;
  logic [NUM_EVT-1:0] sw_clr;
  logic [NUM_EVT-1:0] status;
  logic [NUM_EVT-1:0] enable_q;

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_line_i),
    .q_o   (line_sync)
  );

  irq_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(line_sync),
    .rise_o (ev_rise),
    .fall_o (ev_fall),
    .high_o (ev_high)
  );

  always_comb begin
    ev_set           = '0;
    ev_set[EVT_RISE] = ev_rise;
    ev_set[EVT_HIGH] = ev_high;
    ev_set[EVT_FALL] = ev_fall;
  end

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_flag
    assign sw_clr[k] = wr_en_i & ~wr_data_i[k];
    irq_flag_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (ev_set[k]),
      .clr_i (sw_clr[k]),
      .flag_o(status[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      enable_q <= '0;
    else if (wr_en_i) enable_q <= wr_data_i[EN_BASE +: NUM_EVT];
  end

  if (PAD_W > 0) begin : g_pad
    assign rd_data_o = {{PAD_W{1'b0}}, enable_q, status};
  end else begin : g_nopad
    assign rd_data_o = {enable_q, status};
  end

  assign irq_o = |(status & enable_q);

  initial assert (DATA_W >= USED_W) else $error("irq_event_capture: DATA_W too small");

  assert_enable_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[EN_BASE +: NUM_EVT] == $past(wr_data_i[EN_BASE +: NUM_EVT]));
  assert_masked_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[EN_BASE +: NUM_EVT] == '0) |=> !irq_o);
  assert_irq_needs_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rd_data_o[NUM_EVT-1:0] != '0));
  assert_rise_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(line_sync) && $past(rst_ni)) |=> rd_data_o[EVT_RISE]);
endmodule

// File: tb/sim_irq_event_capture.sv
`timescale 1ns/1ps
module sim_irq_event_capture;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          line = 1'b0;
  logic          wr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;
  int            checks = 0;
  int            failures = 0;

  always #2.5 clk = ~clk;

  irq_event_capture #(.DATA_W(DW)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .irq_line_i(line),
    .wr_en_i   (wr),
    .wr_data_i (wdata),
    .rd_data_o (rdata),
    .irq_o     (irq)
  );

  // {wr, wdata[7:0], line, exp_rd[7:0], exp_irq}
  localparam int NV = 11;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 8'h08, 1'b0, 8'h08, 1'b0},  // R7 enable rise
    {1'b0, 8'h00, 1'b1, 8'h0B, 1'b1},  // R2 R3 rise+high
    {1'b0, 8'h00, 1'b0, 8'h0F, 1'b1},  // R4 fall, R2 sticky
    {1'b1, 8'h08, 1'b0, 8'h08, 1'b0},  // R5 clear all status
    {1'b1, 8'h30, 1'b0, 8'h30, 1'b0},  // R7 high/fall enables
    {1'b0, 8'h00, 1'b1, 8'h33, 1'b1},  // R8 high enabled
    {1'b1, 8'h20, 1'b1, 8'h22, 1'b0},  // R6 level re-sets over clear
    {1'b0, 8'h00, 1'b0, 8'h26, 1'b1},  // R4 fall flag, R3 sticky
    {1'b1, 8'h27, 1'b0, 8'h26, 1'b1},  // R5 ones leave status
    {1'b1, 8'hC0, 1'b0, 8'h00, 1'b0},  // R9 upper bits ignored
    {1'b1, 8'h38, 1'b1, 8'h3B, 1'b1}   // R8 enables then rise
  };

  task automatic check(input string req, input logic [DW-1:0] exp_rd, input logic exp_irq);
    checks++;
    if (rdata !== exp_rd || irq !== exp_irq) begin
      failures++;
      $display("FAIL %s rd=%h irq=%b expected rd=%h irq=%b", req, rdata, irq, exp_rd, exp_irq);
    end
  endtask

  task automatic step(input logic w, input logic [DW-1:0] d, input logic l);
    @(negedge clk);
    line = l; wr = w; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; line = 1'b0; wr = 1'b0; wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    do_reset();
    check("R1 reset", 8'h00, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][18], VEC[i][17:10], VEC[i][9]);
      check($sformatf("vec%0d", i), VEC[i][8:1], VEC[i][0]);
    end

    // R1: reset while flags and enables are set
    do_reset();
    check("R1 reset clears", 8'h00, 1'b0);

    // R2: exact latency of rising status
    step(1'b1, 8'h08, 1'b0);
    @(negedge clk); line = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R2 not yet after two edges", 8'h08, 1'b0);
    @(negedge clk);
    check("R2 set after third edge", 8'h0B, 1'b1);

    // R4: falling latency, no rise flag from a fall
    step(1'b1, 8'h00, 1'b1);   // clear rise, high re-sets (line high)
    check("R3 high stays while line high", 8'h02, 1'b0);
    @(negedge clk); line = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R4 not yet after two edges", 8'h02, 1'b0);
    @(negedge clk);
    check("R4 fall set, rise not set", 8'h06, 1'b0);

    // R6: software clear lands on the same edge as the rising detection
    step(1'b1, 8'h08, 1'b0);
    check("R5 cleared before R6", 8'h08, 1'b0);
    @(negedge clk); line = 1'b1;
    @(negedge clk); @(negedge clk);
    wr = 1'b1; wdata = 8'h08;
    @(negedge clk); wr = 1'b0; wdata = '0;
    check("R6 set wins over clear", 8'h0B, 1'b1);

    // R8: flag set with its enable off does not raise irq
    step(1'b1, 8'h10, 1'b1);
    step(1'b0, 8'h00, 1'b0);
    check("R8 fall masked", 8'h16, 1'b1);
    step(1'b1, 8'h04, 1'b0);
    check("R8 no enable no irq", 8'h04, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired rd=%h irq=%b expected completion", rdata, irq);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule